// File: doc/BRIEF.md
# Programmable interval counter channel

This block is a single 16-bit down-counting channel of an interval timer. A count-enable pulse, derived elsewhere from a fixed reference of nominally 1,193,180 Hz, decrements the count by one step per pulse. The host works through an 8-bit data port. It writes the reload value as two bytes, low byte first. It reads the count back the same way, two bytes at a time.

The channel drives one output line in one of three modes:
- terminal-count interrupt;
- rate generator;
- square wave.

A latch command freezes a snapshot of the count. The snapshot stays in place until both of its bytes have been read. A low-byte write halts the channel until the matching high byte arrives.

A control-word strobe programs the mode or issues the latch. The neighbouring decoder routes the control word to this channel, so the channel-select bits are not looked at here.

Top module: `interval_channel`

## Requirements
- R1: After reset the output is low, the count and the snapshot are zero, no snapshot is pending, and both the write and the read byte pointers select the low byte.
- R2: A data write while the write pointer selects the low byte has these effects:
  - it replaces count bits 7:0 only;
  - it stops counting;
  - it forces the output low;
  - it moves the write pointer to the high byte.
- R3: A data write while the write pointer selects the high byte has these effects:
  - it replaces count bits 15:8;
  - it stores the full 16-bit value as the reload period;
  - it returns the write pointer to the low byte;
  - it starts counting only when the value is nonzero. A zero value leaves the count still.
  - In rate-generator and square-wave modes, a nonzero value sets the output high.
- R4: A control word with access field (bits 5:4) equal to 0 is a latch command. It copies the current count into a snapshot and points the read pointer at the low byte, but only when no snapshot is pending. A latch command while a snapshot is pending changes nothing.
- R5: While a snapshot is pending, the data port shows the snapshot low byte and then its high byte. Each read strobe advances the pointer, and the read of the high byte releases the snapshot.
- R6: With no snapshot pending, the data port shows the live count, low byte and then high byte, alternating on each read strobe.
- R7: Terminal-count interrupt mode (mode field 0) behaves as follows:
  - each enable pulse decrements the count by 1;
  - when the count reaches zero, the output goes high and counting stops;
  - the output stays high until the next low-byte write.
- R8: Rate-generator mode (mode field 2) behaves as follows:
  - each enable pulse decrements the count by 1;
  - the output is low for exactly the enable period during which the count is 1;
  - the next pulse reloads the period and returns the output high.
- R9: Square-wave mode (mode field 3) behaves as follows:
  - each enable pulse decrements the count by 2;
  - a pulse that finds the count at 2 or below reloads the period with bit 0 cleared and toggles the output, so the output flips every half period.
- R10: A mode-setting control word is honoured only when all of these hold:
  - the access field is 3;
  - the mode field (bits 3:1) is 0, 2 or 3;
  - bit 0 (decimal counting) is 0.
  Any other non-latch word leaves the mode unchanged.
- R11: A count-enable pulse changes the count only while the channel is running. In a cycle that also carries a data write, the write takes effect and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable pulse, one step per cycle high |
| ctrl_wr | input | 1 | Control word strobe |
| ctrl_byte | input | 8 | Control word: bits 5:4 access, 3:1 mode, 0 decimal |
| data_wr | input | 1 | Data write strobe |
| data_in | input | 8 | Count byte written |
| data_rd | input | 1 | Data read strobe, advances the read pointer |
| data_out | output | 8 | Count byte currently selected for reading |
| tmr_out | output | 1 | Channel output line |

## Verification
The bench builds the channel with its default 8-bit byte width, which gives the 16-bit count. This makes the byte-split corner cases reachable:
- a low-byte-only load, in which the upper byte is kept;
- latched values with a nonzero high byte;
- a count that borrows across the byte boundary.

Small reload values (4 and 6) keep the reload and toggle points of the rate-generator and square-wave modes within a few dozen cycles. A value of 0x0100 makes the snapshot observably differ from the live count after later pulses.

// File: rtl/ich_pkg.sv
package ich_pkg;
  localparam logic [2:0] MODE_TC   = 3'd0;
  localparam logic [2:0] MODE_RATE = 3'd2;
  localparam logic [2:0] MODE_SQR  = 3'd3;
  localparam logic [1:0] ACC_LATCH = 2'd0;
  localparam logic [1:0] ACC_WORD  = 2'd3;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQR);
  endfunction
endpackage

// File: rtl/ich_ctrl_dec.sv
module ich_ctrl_dec
  import ich_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] ctrl_byte,
  output logic              latch_cmd,
  output logic [2:0]        mode_q
);
  logic [1:0] acc;
  logic [2:0] mfield;
  logic       mode_ld;
  logic [2:0] mode_d;

  assign acc       = ctrl_byte[5:4];
  assign mfield    = ctrl_byte[3:1];
  assign latch_cmd = ctrl_wr && (acc == ACC_LATCH);
  assign mode_ld   = ctrl_wr && (acc == ACC_WORD) && !ctrl_byte[0] && mode_ok(mfield);

  always_comb begin
    mode_d = mode_q;
    if (mode_ld) mode_d = mfield;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_TC;
    else        mode_q <= mode_d;
  end

  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(mode_q));
  assert_bad_word_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && acc != ACC_LATCH && (ctrl_byte[0] || !mode_ok(mfield))) |=> $stable(mode_q));
endmodule

// File: rtl/ich_core.sv
module ich_core
  import ich_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [2:0]          mode,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic                out_q
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_d, per_q, per_d, full, nxt, per_even;
  logic             run_q, run_d, out_d, wptr_q, wptr_d;

  assign full     = {wr_data, cnt_q[BYTE_W-1:0]};
  assign per_even = {per_q[CNT_W-1:1], 1'b0};

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    run_d  = run_q;
    out_d  = out_q;
    wptr_d = wptr_q;
    nxt    = cnt_q;
    if (wr_en) begin
      if (!wptr_q) begin
        cnt_d[BYTE_W-1:0] = wr_data;
        run_d  = 1'b0;
        out_d  = 1'b0;
        wptr_d = 1'b1;
      end else begin
        cnt_d  = full;
        per_d  = full;
        run_d  = (full != '0);
        out_d  = (mode != MODE_TC) && (full != '0);
        wptr_d = 1'b0;
      end
    end else if (tick && run_q) begin
      unique case (mode)
        MODE_RATE: begin
          nxt   = (cnt_q == CNT_W'(1)) ? per_q : cnt_q - CNT_W'(1);
          cnt_d = nxt;
          out_d = (nxt != CNT_W'(1));
        end
        MODE_SQR: begin
          if (cnt_q <= CNT_W'(2)) begin
            cnt_d = per_even;
            out_d = !out_q;
          end else begin
            cnt_d = cnt_q - CNT_W'(2);
          end
        end
        default: begin
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            out_d = 1'b1;
            run_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      run_q  <= 1'b0;
      out_q  <= 1'b0;
      wptr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      run_q  <= run_d;
      out_q  <= out_d;
      wptr_q <= wptr_d;
    end
  end

  assert_low_write_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wptr_q) |=> (!out_q && !run_q && wptr_q));
  assert_zero_load_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wptr_q && full == '0) |=> !run_q);
  assert_tc_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TC && out_q && !wr_en && !tick) |=> out_q);
  assert_rate_dip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RATE && run_q && tick && !wr_en && cnt_q == CNT_W'(2)) |=> !out_q);
  assert_sqr_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SQR && run_q && tick && !wr_en && cnt_q <= CNT_W'(2)) |=> (out_q != $past(out_q)));
  assert_idle_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/ich_snap.sv
module ich_snap #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch_cmd,
  input  logic                rd_en,
  input  logic [2*BYTE_W-1:0] live,
  output logic [BYTE_W-1:0]   rd_data
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] hold_q, hold_d, src;
  logic             pend_q, pend_d, rptr_q, rptr_d;

  always_comb begin
    hold_d = hold_q;
    pend_d = pend_q;
    rptr_d = rptr_q;
    if (latch_cmd && !pend_q) begin
      hold_d = live;
      pend_d = 1'b1;
      rptr_d = 1'b0;
    end else if (rd_en) begin
      rptr_d = !rptr_q;
      if (rptr_q) pend_d = 1'b0;
    end
  end

  assign src     = pend_q ? hold_q : live;
  assign rd_data = rptr_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      rptr_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
      rptr_q <= rptr_d;
    end
  end

  assert_snapshot_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(hold_q));
  assert_high_read_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rd_en && rptr_q && !latch_cmd) |=> !pend_q);
endmodule

// File: rtl/interval_channel.sv
module interval_channel #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] ctrl_byte,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              data_rd,
  output logic [BYTE_W-1:0] data_out,
  output logic              tmr_out
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             latch_cmd;
  logic [2:0]       mode;
  logic [CNT_W-1:0] cnt;

  ich_ctrl_dec #(.BYTE_W(BYTE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_byte(ctrl_byte),
    .latch_cmd(latch_cmd), .mode_q(mode)
  );

  ich_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(data_wr), .wr_data(data_in),
    .mode(mode), .cnt_q(cnt), .out_q(tmr_out)
  );

  ich_snap #(.BYTE_W(BYTE_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .latch_cmd(latch_cmd), .rd_en(data_rd),
    .live(cnt), .rd_data(data_out)
  );
endmodule

// File: tb/interval_channel_tb.sv
`timescale 1ns/1ps
module interval_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, ctrl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] ctrl_byte = 8'h00, data_in = 8'h00;
  logic [7:0] data_out;
  logic       tmr_out;

  int    total = 0, bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  interval_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr), .ctrl_byte(ctrl_byte),
    .data_wr(data_wr), .data_in(data_in), .data_rd(data_rd),
    .data_out(data_out), .tmr_out(tmr_out)
  );

  // behavioural reference
  int m_cnt, m_per, m_hold, m_mode;
  bit m_run, m_out, m_wptr, m_pend, m_rptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_hold = 0; m_mode = 0;
      m_run = 0; m_out = 0; m_wptr = 0; m_pend = 0; m_rptr = 0;
    end else begin
      int old_cnt, md, full;
      old_cnt = m_cnt;
      if (data_wr) begin
        if (!m_wptr) begin
          m_cnt = (m_cnt & 16'hFF00) | data_in;
          m_run = 0; m_out = 0; m_wptr = 1;
        end else begin
          full = (data_in << 8) | (m_cnt & 8'hFF);
          m_cnt = full; m_per = full; m_run = (full != 0);
          m_out = (m_mode != 0) && (full != 0); m_wptr = 0;
        end
      end else if (tick && m_run) begin
        if (m_mode == 2) begin
          m_cnt = (m_cnt == 1) ? m_per : m_cnt - 1;
          m_out = (m_cnt != 1);
        end else if (m_mode == 3) begin
          if (m_cnt <= 2) begin m_cnt = m_per & 16'hFFFE; m_out = !m_out; end
          else m_cnt = m_cnt - 2;
        end else begin
          if (m_cnt == 1) begin m_out = 1; m_run = 0; end
          m_cnt = (m_cnt - 1) & 16'hFFFF;
        end
      end
      if (ctrl_wr && ctrl_byte[5:4] == 2'd0 && !m_pend) begin
        m_pend = 1; m_hold = old_cnt; m_rptr = 0;
      end else if (data_rd) begin
        if (m_rptr) m_pend = 0;
        m_rptr = !m_rptr;
      end
      md = int'(ctrl_byte[3:1]);
      if (ctrl_wr && ctrl_byte[5:4] == 2'd3 && !ctrl_byte[0] && (md == 0 || md == 2 || md == 3))
        m_mode = md;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_byte();
    int src;
    src = m_pend ? m_hold : m_cnt;
    return m_rptr ? (src >> 8) & 8'hFF : src & 8'hFF;
  endfunction

  always @(negedge clk) if (rst_n) begin
    chk({cur_req, " cycle out"}, int'(tmr_out), int'(m_out));
    chk({cur_req, " cycle data"}, int'(data_out), exp_byte());
  end

  task automatic ctrl(input logic [7:0] w);
    @(negedge clk); ctrl_byte = w; ctrl_wr = 1;
    @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wbyte(input logic [7:0] b);
    @(negedge clk); data_in = b; data_wr = 1;
    @(negedge clk); data_wr = 0;
  endtask
  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask
  task automatic rbyte(output logic [7:0] b);
    @(negedge clk); #1 b = data_out; data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  logic done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(negedge clk);
    chk("R1 out", int'(tmr_out), 0);
    chk("R1 data", int'(data_out), 0);
    rst_n = 1;

    // R7 terminal count
    cur_req = "R7";
    ctrl(8'h30); wbyte(8'h05); wbyte(8'h00);
    ticks(5);
    @(negedge clk); chk("R7 out high at zero", int'(tmr_out), 1);
    ticks(3);
    @(negedge clk); chk("R7 out held", int'(tmr_out), 1);
    cur_req = "R2";
    wbyte(8'h07);
    @(negedge clk); chk("R2 out low after low write", int'(tmr_out), 0);
    chk("R2 low byte replaced", int'(data_out), 8'h07);
    ticks(3);
    @(negedge clk); chk("R2 halted", int'(data_out), 8'h07);

    // R3 zero load
    cur_req = "R3";
    wbyte(8'h00);
    wbyte(8'h00); wbyte(8'h00);
    ticks(4);
    @(negedge clk); chk("R3 zero load idle", int'(data_out), 0);
    chk("R3 zero load out", int'(tmr_out), 0);

    // R6 live reads
    cur_req = "R6";
    wbyte(8'h34); wbyte(8'h12);
    ctrl(8'h30);
    wbyte(8'h34); wbyte(8'h12);
    rbyte(lo); rbyte(hi);
    chk("R6 live low", int'(lo), 8'h34);
    chk("R6 live high", int'(hi), 8'h12);

    // R4/R5 snapshot
    cur_req = "R4";
    wbyte(8'h00); wbyte(8'h01);
    ticks(3);
    ctrl(8'h00);
    ticks(2);
    ctrl(8'h00);
    cur_req = "R5";
    rbyte(lo); rbyte(hi);
    chk("R4 R5 snapshot low", int'(lo), 8'hFD);
    chk("R5 snapshot high", int'(hi), 8'h00);
    rbyte(lo);
    chk("R5 released live low", int'(lo), 8'hFB);
    rbyte(hi);

    // R11 write wins over tick
    cur_req = "R11";
    @(negedge clk); data_in = 8'h09; data_wr = 1; tick = 1;
    @(negedge clk); data_wr = 0; tick = 0;
    chk("R11 write wins", int'(data_out), 8'h09);
    wbyte(8'h00);

    // R8 rate generator
    cur_req = "R8";
    ctrl(8'h34); wbyte(8'h04); wbyte(8'h00);
    @(negedge clk); chk("R8 out high on load", int'(tmr_out), 1);
    ticks(3);
    @(negedge clk); chk("R8 dip at one", int'(tmr_out), 0);
    ticks(1);
    @(negedge clk); chk("R8 reload", int'(data_out), 8'h04);
    chk("R8 out back high", int'(tmr_out), 1);
    ticks(12);

    // R9 square wave
    cur_req = "R9";
    ctrl(8'h36); wbyte(8'h06); wbyte(8'h00);
    ticks(3);
    @(negedge clk); chk("R9 first half toggles", int'(tmr_out), 0);
    ticks(3);
    @(negedge clk); chk("R9 second half toggles", int'(tmr_out), 1);

    // R10 rejected words
    cur_req = "R10";
    ctrl(8'h3A); ctrl(8'h10); ctrl(8'h31);
    ticks(3);
    @(negedge clk); chk("R10 mode kept square", int'(tmr_out), 0);
    ticks(9);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule